// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. Each entry maps a virtual page number, qualified by an address-space tag, to a physical frame number and a set of permission flags. An entry can describe a small page, a medium page that spans 512 small pages, or a large page that spans 262,144 small pages. An entry marked global answers for every address space. Entries that are neither global nor tagged with the current tag stay resident but do not answer. A lookup is accepted on one clock edge, and the hit or miss answer with the translated frame appears on the next edge.

The processor side loads the current address-space tag through a context port. A per-load control bit selects whether the existing entries survive the switch or are all dropped. An invalidation port removes entries in one of three ways: all at once, every entry covering one virtual page whatever its tag, or every non-global entry carrying one tag. Translations come in through a refill port. A refill goes to the lowest free slot. When no slot is free it replaces the least recently used entry. If the refill describes a page that an entry already holds for the same tag and size, it rewrites that entry in place.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: A lookup presented with `lk_req` on one rising edge gives `lk_rsp_valid` = 1 on the next edge. `lk_hit` is 1 when a valid entry covers `lk_vpn` and its tag equals the current tag. When `lk_hit` is 1, `lk_flags` and `lk_size` are the stored values. When `lk_hit` is 0, `lk_pfn`, `lk_flags` and `lk_size` are zero.
- R3: An entry whose global flag (`fill_flags` bit 5) is set matches under any current tag.
- R4: `fill_size` encodes 0 = 4 KB, 1 = 2 MB and 2 = 1 GB. The value 3 behaves as 4 KB. Matching ignores the low 9 virtual page bits of a 2 MB entry and the low 18 bits of a 1 GB entry. The returned frame takes those low bits from `lk_vpn` and the rest from the stored frame.
- R5: A context load with `ctx_keep` = 1 sets the current tag and keeps every entry. With `ctx_keep` = 0 it sets the tag and invalidates every entry.
- R6: An invalidation with `inv_op` = 1 invalidates every entry.
- R7: An invalidation with `inv_op` = 2 invalidates every entry, global or not and whatever its tag, whose page covers `inv_vpn`.
- R8: An invalidation with `inv_op` = 3 invalidates only the non-global entries tagged `inv_asid`. Global entries and entries with other tags remain.
- R9: A refill that matches no entry is written into the lowest-numbered invalid entry. When every entry is valid, it replaces the least recently used entry. Both lookup hits and refills count as uses.
- R10: A refill whose tag, size and covered page equal those of a valid entry overwrites that entry in place and allocates nothing new.
- R11: Operations in the same cycle are prioritised. A flushing context load or any invalidation (`inv_op` ≠ 0) suppresses a refill in that cycle. The `inv_op` codes are 0 = none, 1 = all, 2 = by address and 3 = by tag. A lookup in the same cycle sees the state and the tag from before that edge.
- R12: The flags are returned with a hit exactly as they were filled. Bit 0 is present, bit 1 dirty, bit 2 accessed, bit 3 no-execute, bit 4 user and bit 5 global. A clear present bit does not prevent a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_load | input | 1 | Load a new current address-space tag |
| ctx_asid | input | ASID_W | Tag to load |
| ctx_keep | input | 1 | 1 keeps the entries on the load, 0 drops all of them |
| inv_req | input | 1 | Invalidation strobe |
| inv_op | input | 2 | 0 none, 1 all, 2 by address, 3 by tag |
| inv_vpn | input | VPN_W | Page used by invalidation by address |
| inv_asid | input | ASID_W | Tag used by invalidation by tag |
| fill_req | input | 1 | Refill strobe |
| fill_vpn | input | VPN_W | Virtual page of the refill |
| fill_asid | input | ASID_W | Tag of the refill |
| fill_pfn | input | PFN_W | Physical frame of the refill |
| fill_size | input | 2 | Page size code |
| fill_flags | input | 6 | Flags as listed in R12 |
| lk_req | input | 1 | Lookup strobe |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_rsp_valid | output | 1 | Lookup answer present |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Translated frame |
| lk_flags | output | 6 | Flags of the hitting entry |
| lk_size | output | 2 | Size code of the hitting entry |

## Verification
The assertions assume that reset is held over at least one rising edge before any strobe. They also assume that `inv_op` is a defined code whenever `inv_req` is high, and that at most one refill arrives per cycle. The bound checks then cover every cycle: response timing, flushes emptying the table, tag invalidation leaving no stale non-global entry, and at most one new entry per cycle. The stimulus drives every strobe on the falling edge with all fields settled, and it releases reset only after four edges. It collides operations on purpose only in the priority cases of R11.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

   typedef enum logic [1:0] {
      INV_NONE = 2'd0,
      INV_ALL  = 2'd1,
      INV_ADDR = 2'd2,
      INV_TAG  = 2'd3
   } inv_op_e;

   localparam int MID_IGN_BITS = 9;
   localparam int BIG_IGN_BITS = 18;
   localparam int FLAG_W       = 6;
   localparam int FLAG_GLOBAL  = 5;

   // number of low page bits a size code leaves out of the compare
   function automatic int ign_bits(input logic [1:0] sz);
      case (sz)
         2'd1:    ign_bits = MID_IGN_BITS;
         2'd2:    ign_bits = BIG_IGN_BITS;
         default: ign_bits = 0;
      endcase
   endfunction

endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp #(
   parameter int VPN_W  = 36,
   parameter int ASID_W = 12
) (
   input  logic              e_valid,
   input  logic [VPN_W-1:0]  e_vpn,
   input  logic [ASID_W-1:0] e_asid,
   input  logic [1:0]        e_size,
   input  logic              e_global,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic [VPN_W-1:0]  fl_vpn,
   input  logic [ASID_W-1:0] fl_asid,
   input  logic [1:0]        fl_size,
   output logic              lk_hit,
   output logic              addr_hit,
   output logic              id_hit,
   output logic              fill_hit
);
   import asid_tlb_pkg::*;

   logic [VPN_W-1:0] cmp_mask;

   always_comb begin
      for (int i = 0; i < VPN_W; i++) begin
         cmp_mask[i] = (i >= ign_bits(e_size));
      end
   end

   always_comb begin
      lk_hit   = e_valid && (((e_vpn ^ lk_vpn) & cmp_mask) == '0)
                 && (e_global || (e_asid == cur_asid));
      addr_hit = e_valid && (((e_vpn ^ inv_vpn) & cmp_mask) == '0);
      id_hit   = e_valid && !e_global && (e_asid == inv_asid);
      fill_hit = e_valid && (e_size == fl_size) && (e_asid == fl_asid)
                 && (((e_vpn ^ fl_vpn) & cmp_mask) == '0);
   end

endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
   parameter int N  = 64,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
   parameter int N  = 64,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim
);
   // each entry holds its recency rank: 0 newest, N-1 oldest
   logic [N-1:0][IW-1:0] rank_q;
   logic [IW-1:0]        touched_rank;

   assign touched_rank = rank_q[touch_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) rank_q[i] <= IW'(i);
      end else if (touch) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)            rank_q[i] <= '0;
            else if (rank_q[i] < touched_rank)  rank_q[i] <= rank_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int i = 0; i < N; i++) begin
         if (rank_q[i] == IW'(N - 1)) victim = IW'(i);
      end
   end

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 36,
   parameter int PFN_W   = 28,
   parameter int ASID_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctx_load,
   input  logic [ASID_W-1:0] ctx_asid,
   input  logic              ctx_keep,
   input  logic              inv_req,
   input  logic [1:0]        inv_op,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic              fill_req,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic [1:0]        fill_size,
   input  logic [5:0]        fill_flags,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_rsp_valid,
   output logic              lk_hit,
   output logic [PFN_W-1:0]  lk_pfn,
   output logic [5:0]        lk_flags,
   output logic [1:0]        lk_size
);
   import asid_tlb_pkg::*;

   localparam int IW = $clog2(ENTRIES);

   // elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("asid_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W <= BIG_IGN_BITS || PFN_W <= BIG_IGN_BITS) begin : g_bad_width
      $error("asid_tlb: page number widths must exceed the large-page offset");
   end
   if (ASID_W < 1 || ASID_W > 16) begin : g_bad_asid
      $error("asid_tlb: ASID_W out of range");
   end

   // entry storage
   logic [ENTRIES-1:0]                  valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]       vpn_q;
   logic [ENTRIES-1:0][PFN_W-1:0]       pfn_q;
   logic [ENTRIES-1:0][ASID_W-1:0]      asid_q;
   logic [ENTRIES-1:0][1:0]             size_q;
   logic [ENTRIES-1:0][FLAG_W-1:0]      flg_q;
   logic [ENTRIES-1:0]                  glob_v;
   logic [ASID_W-1:0]                   cur_asid_q;

   // per-entry compare results
   logic [ENTRIES-1:0] lk_m, addr_m, id_m, fill_m;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign glob_v[g] = flg_q[g][FLAG_GLOBAL];
      tlb_entry_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) u_cmp (
         .e_valid  (valid_q[g]),
         .e_vpn    (vpn_q[g]),
         .e_asid   (asid_q[g]),
         .e_size   (size_q[g]),
         .e_global (glob_v[g]),
         .lk_vpn   (lk_vpn),
         .cur_asid (cur_asid_q),
         .inv_vpn  (inv_vpn),
         .inv_asid (inv_asid),
         .fl_vpn   (fill_vpn),
         .fl_asid  (fill_asid),
         .fl_size  (fill_size),
         .lk_hit   (lk_m[g]),
         .addr_hit (addr_m[g]),
         .id_hit   (id_m[g]),
         .fill_hit (fill_m[g])
      );
   end

   // index selection
   logic          lk_any, fm_any, free_any;
   logic [IW-1:0] lk_idx, fm_idx, free_idx, lru_idx, fill_idx;

   tlb_pick #(.N(ENTRIES)) u_pick_lk   (.req(lk_m),     .any(lk_any),   .idx(lk_idx));
   tlb_pick #(.N(ENTRIES)) u_pick_fill (.req(fill_m),   .any(fm_any),   .idx(fm_idx));
   tlb_pick #(.N(ENTRIES)) u_pick_free (.req(~valid_q), .any(free_any), .idx(free_idx));

   // operation decode with priority: flush > invalidate > refill
   inv_op_e op;
   logic    ctx_flush, inv_live, do_flush, do_addr, do_tag, do_fill;

   always_comb begin
      op        = inv_op_e'(inv_op);
      ctx_flush = ctx_load && !ctx_keep;
      inv_live  = inv_req && (op != INV_NONE);
      do_flush  = ctx_flush || (inv_req && op == INV_ALL);
      do_addr   = !ctx_flush && inv_req && op == INV_ADDR;
      do_tag    = !ctx_flush && inv_req && op == INV_TAG;
      do_fill   = fill_req && !ctx_flush && !inv_live;
      fill_idx  = fm_any ? fm_idx : (free_any ? free_idx : lru_idx);
   end

   // recency tracking: a refill wins over a lookup hit in the same cycle
   logic          touch;
   logic [IW-1:0] touch_idx;

   always_comb begin
      touch     = do_fill || (lk_req && lk_any);
      touch_idx = do_fill ? fill_idx : lk_idx;
   end

   tlb_lru #(.N(ENTRIES)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (touch),
      .touch_idx (touch_idx),
      .victim    (lru_idx)
   );

   // valid bits and current tag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q    <= '0;
         cur_asid_q <= '0;
      end else begin
         if (ctx_load) cur_asid_q <= ctx_asid;
         for (int i = 0; i < ENTRIES; i++) begin
            if (do_flush)                             valid_q[i] <= 1'b0;
            else if (do_addr && addr_m[i])            valid_q[i] <= 1'b0;
            else if (do_tag && id_m[i])               valid_q[i] <= 1'b0;
            else if (do_fill && IW'(i) == fill_idx)   valid_q[i] <= 1'b1;
         end
      end
   end

   // entry payload, written only by refill
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vpn_q  <= '0;
         pfn_q  <= '0;
         asid_q <= '0;
         size_q <= '0;
         flg_q  <= '0;
      end else if (do_fill) begin
         vpn_q[fill_idx]  <= fill_vpn;
         pfn_q[fill_idx]  <= fill_pfn;
         asid_q[fill_idx] <= fill_asid;
         size_q[fill_idx] <= fill_size;
         flg_q[fill_idx]  <= fill_flags;
      end
   end

   // frame merge: low frame bits come from the page offset of a large entry
   logic [PFN_W-1:0] sel_pfn, merged_pfn;
   logic [1:0]       sel_size;

   always_comb begin
      sel_pfn  = pfn_q[lk_idx];
      sel_size = size_q[lk_idx];
      for (int i = 0; i < PFN_W; i++) begin
         merged_pfn[i] = (i < ign_bits(sel_size)) ? lk_vpn[i] : sel_pfn[i];
      end
   end

   // registered lookup answer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_rsp_valid <= 1'b0;
         lk_hit       <= 1'b0;
         lk_pfn       <= '0;
         lk_flags     <= '0;
         lk_size      <= '0;
      end else begin
         lk_rsp_valid <= lk_req;
         lk_hit       <= lk_req && lk_any;
         lk_pfn       <= (lk_req && lk_any) ? merged_pfn      : '0;
         lk_flags     <= (lk_req && lk_any) ? flg_q[lk_idx]   : '0;
         lk_size      <= (lk_req && lk_any) ? sel_size        : '0;
      end
   end

endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
   parameter int N      = 64,
   parameter int ASID_W = 12
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      lk_req,
   input logic                      lk_rsp_valid,
   input logic                      lk_hit,
   input logic                      ctx_load,
   input logic                      ctx_keep,
   input logic                      inv_req,
   input logic [1:0]                inv_op,
   input logic [ASID_W-1:0]         inv_asid,
   input logic                      fill_req,
   input logic [N-1:0]              valid_q,
   input logic [N-1:0][ASID_W-1:0]  asid_q,
   input logic [N-1:0]              glob_v
);
   // record a tag invalidation so the following cycle can be checked
   logic              tag_inv_seen;
   logic [ASID_W-1:0] tag_inv_id;
   logic              stale_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_inv_seen <= 1'b0;
         tag_inv_id   <= '0;
      end else begin
         tag_inv_seen <= inv_req && (inv_op == 2'd3);
         tag_inv_id   <= inv_asid;
      end
   end

   always_comb begin
      stale_left = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (valid_q[i] && !glob_v[i] && asid_q[i] == tag_inv_id) stale_left = 1'b1;
      end
   end

   assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_rsp_valid);

   assert_hit_within_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_rsp_valid);

   assert_flush_load_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_load && !ctx_keep) |=> (valid_q == '0));

   assert_keep_load_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_load && ctx_keep && !inv_req && !fill_req) |=> $stable(valid_q));

   assert_inv_all_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req && inv_op == 2'd1) |=> (valid_q == '0));

   assert_tag_inv_no_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tag_inv_seen |-> !stale_left);

   assert_one_alloc_per_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(valid_q) <= $countones($past(valid_q)) + 1);

   assert_inv_blocks_fill_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_req && inv_op != 2'd0 && fill_req) |=> ($countones(valid_q) <= $countones($past(valid_q))));

endmodule

bind asid_tlb asid_tlb_chk #(.N(ENTRIES), .ASID_W(ASID_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lk_req       (lk_req),
   .lk_rsp_valid (lk_rsp_valid),
   .lk_hit       (lk_hit),
   .ctx_load     (ctx_load),
   .ctx_keep     (ctx_keep),
   .inv_req      (inv_req),
   .inv_op       (inv_op),
   .inv_asid     (inv_asid),
   .fill_req     (fill_req),
   .valid_q      (valid_q),
   .asid_q       (asid_q),
   .glob_v       (glob_v)
);

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
   localparam int ENT = 8;
   localparam int VW  = 36;
   localparam int PW  = 28;
   localparam int AW  = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctx_load = 0, ctx_keep = 0;
   logic [AW-1:0] ctx_asid = '0;
   logic          inv_req = 0;
   logic [1:0]    inv_op = '0;
   logic [VW-1:0] inv_vpn = '0;
   logic [AW-1:0] inv_asid = '0;
   logic          fill_req = 0;
   logic [VW-1:0] fill_vpn = '0;
   logic [AW-1:0] fill_asid = '0;
   logic [PW-1:0] fill_pfn = '0;
   logic [1:0]    fill_size = '0;
   logic [5:0]    fill_flags = '0;
   logic          lk_req = 0;
   logic [VW-1:0] lk_vpn = '0;
   logic          lk_rsp_valid, lk_hit;
   logic [PW-1:0] lk_pfn;
   logic [5:0]    lk_flags;
   logic [1:0]    lk_size;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;  // 250 MHz

   asid_tlb #(.ENTRIES(ENT), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u_asid_tlb (
      .clk(clk), .rst_n(rst_n),
      .ctx_load(ctx_load), .ctx_asid(ctx_asid), .ctx_keep(ctx_keep),
      .inv_req(inv_req), .inv_op(inv_op), .inv_vpn(inv_vpn), .inv_asid(inv_asid),
      .fill_req(fill_req), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
      .fill_pfn(fill_pfn), .fill_size(fill_size), .fill_flags(fill_flags),
      .lk_req(lk_req), .lk_vpn(lk_vpn),
      .lk_rsp_valid(lk_rsp_valid), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
      .lk_flags(lk_flags), .lk_size(lk_size)
   );

   typedef struct packed {
      logic [35:0] vpn;
      logic        hit;
      logic [27:0] pfn;
      logic [5:0]  flags;
      logic [1:0]  size;
      logic [3:0]  req;   // requirement number for the message
   } look_t;

   // lookups under current tag 5 after the four fills of the table test
   localparam look_t LOOKS [7] = '{
      '{36'h00100, 1'b1, 28'h00000A0, 6'h07, 2'd0, 4'd2},
      '{36'h00101, 1'b0, 28'h0000000, 6'h00, 2'd0, 4'd2},
      '{36'h40305, 1'b1, 28'h0000505, 6'h0F, 2'd1, 4'd4},
      '{36'h40405, 1'b0, 28'h0000000, 6'h00, 2'd0, 4'd4},
      '{36'h00300, 1'b0, 28'h0000000, 6'h00, 2'd0, 4'd2},
      '{36'h81234, 1'b1, 28'h0041234, 6'h21, 2'd2, 4'd3},
      '{36'hC0000, 1'b0, 28'h0000000, 6'h00, 2'd0, 4'd4}
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle with any mix of operations
   task automatic step(input bit cl, input logic [AW-1:0] ca, input bit ck,
                       input bit ir, input logic [1:0] io, input logic [VW-1:0] iv,
                       input logic [AW-1:0] ia,
                       input bit fr, input logic [AW-1:0] fa, input logic [VW-1:0] fv,
                       input logic [PW-1:0] fp, input logic [1:0] fs, input logic [5:0] ff);
      @(negedge clk);
      ctx_load = cl; ctx_asid = ca; ctx_keep = ck;
      inv_req = ir; inv_op = io; inv_vpn = iv; inv_asid = ia;
      fill_req = fr; fill_asid = fa; fill_vpn = fv; fill_pfn = fp;
      fill_size = fs; fill_flags = ff;
      @(negedge clk);
      ctx_load = 0; inv_req = 0; fill_req = 0;
   endtask

   task automatic fill(input logic [AW-1:0] a, input logic [VW-1:0] v,
                       input logic [PW-1:0] p, input logic [1:0] s, input logic [5:0] f);
      step(0, '0, 0, 0, 2'd0, '0, '0, 1, a, v, p, s, f);
   endtask

   task automatic ctx(input logic [AW-1:0] a, input bit keep);
      step(1, a, keep, 0, 2'd0, '0, '0, 0, '0, '0, '0, 2'd0, '0);
   endtask

   task automatic inv(input logic [1:0] o, input logic [VW-1:0] v, input logic [AW-1:0] a);
      step(0, '0, 0, 1, o, v, a, 0, '0, '0, '0, 2'd0, '0);
   endtask

   // lookup: answer registered on the edge after the request
   task automatic look(input logic [VW-1:0] v, input bit eh, input logic [PW-1:0] ep,
                       input string req);
      @(negedge clk);
      lk_req = 1; lk_vpn = v;
      @(negedge clk);
      lk_req = 0;
      check({req, " rsp_valid"}, 64'(lk_rsp_valid), 64'd1);
      check({req, " hit"}, 64'(lk_hit), 64'(eh));
      if (eh) check({req, " pfn"}, 64'(lk_pfn), 64'(ep));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1: empty after reset
      check("R1 rsp idle", 64'(lk_rsp_valid), 64'd0);
      look(36'h00100, 0, '0, "R1");
      look(36'h80000, 0, '0, "R1");

      // table-driven lookups (R2 R3 R4 R12)
      ctx(12'd5, 1);
      fill(12'd5, 36'h00100, 28'hA0,    2'd0, 6'h07);
      fill(12'd5, 36'h40200, 28'h400,   2'd1, 6'h0F);
      fill(12'd7, 36'h00300, 28'hB0,    2'd0, 6'h01);
      fill(12'd9, 36'h80000, 28'h40000, 2'd2, 6'h21);
      for (int i = 0; i < 7; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", LOOKS[i].req, i);
         look(LOOKS[i].vpn, LOOKS[i].hit, LOOKS[i].pfn, tag);
         if (LOOKS[i].hit) begin
            check({tag, " R12 flags"}, 64'(lk_flags), 64'(LOOKS[i].flags));
            check({tag, " size"}, 64'(lk_size), 64'(LOOKS[i].size));
         end else begin
            check({tag, " R2 zero pfn"}, 64'(lk_pfn), 64'd0);
         end
      end

      // R5: keeping switch to tag 7
      ctx(12'd7, 1);
      look(36'h00300, 1, 28'hB0, "R5 keep tag7");
      look(36'h00100, 0, '0, "R5 other tag hidden");
      look(36'h80011, 1, 28'h40011, "R3 global under tag7");

      // R8: invalidate tag 7
      inv(2'd3, '0, 12'd7);
      look(36'h00300, 0, '0, "R8 tag7 removed");
      look(36'h80011, 1, 28'h40011, "R8 global kept");
      ctx(12'd5, 1);
      look(36'h00100, 1, 28'hA0, "R8 tag5 kept");

      // R7: invalidate by address inside the 2 MB page, and the global 1 GB page
      inv(2'd2, 36'h40300, '0);
      look(36'h40305, 0, '0, "R7 mid page removed");
      look(36'h00100, 1, 28'hA0, "R7 other kept");
      inv(2'd2, 36'h80005, 12'd3);
      look(36'h81234, 0, '0, "R7 global removed");

      // R10: refill of an existing page rewrites it
      fill(12'd5, 36'h00100, 28'hCC, 2'd0, 6'h01);
      look(36'h00100, 1, 28'hCC, "R10 overwrite");

      // R6 + R11: invalidate-all collides with a refill
      step(0, '0, 0, 1, 2'd1, '0, '0, 1, 12'd5, 36'h00500, 28'h55, 2'd0, 6'h01);
      look(36'h00100, 0, '0, "R6 all removed");
      look(36'h00500, 0, '0, "R11 fill suppressed by inv");

      // R5 + R11: flushing load collides with a refill
      fill(12'd5, 36'h00600, 28'h66, 2'd0, 6'h01);
      look(36'h00600, 1, 28'h66, "R5 before flush");
      step(1, 12'd5, 0, 0, 2'd0, '0, '0, 1, 12'd5, 36'h00700, 28'h77, 2'd0, 6'h01);
      look(36'h00600, 0, '0, "R5 flush load");
      look(36'h00700, 0, '0, "R11 fill suppressed by flush");

      // R9: fill all eight slots, use page 0, then force a replacement
      for (int k = 0; k < ENT; k++)
         fill(12'd5, 36'h01000 + VW'(k), 28'h200 + PW'(k), 2'd0, 6'h01);
      look(36'h01000, 1, 28'h200, "R9 touch page0");
      fill(12'd5, 36'h01008, 28'h208, 2'd0, 6'h01);
      look(36'h01001, 0, '0, "R9 lru page1 evicted");
      look(36'h01000, 1, 28'h200, "R9 recent page0 kept");
      look(36'h01008, 1, 28'h208, "R9 new page");

      // R10: overwrite page5 while full; a duplicate would evict page2
      fill(12'd5, 36'h01005, 28'h2F5, 2'd0, 6'h01);
      look(36'h01005, 1, 28'h2F5, "R10 full overwrite");
      for (int k = 0; k < ENT + 1; k++) begin
         if (k != 1 && k != 5)
            look(36'h01000 + VW'(k), 1, 28'h200 + PW'(k), "R10 no duplicate");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule